// File: doc/BRIEF.md
# Stack Pointer Frame Sequencer

This block owns a 16-bit stack pointer kept as an upper and a lower byte. It turns single command strobes into byte-wide memory traffic. The strobes cover pushing or popping one byte, a subroutine call, a subroutine return, interrupt entry and interrupt return. Each stored byte takes one clock. Before a byte is written, the pointer moves down. After a byte is read, the pointer moves up. The pointer therefore always names the byte now on top of the stack. A call saves the program counter as two bytes. An interrupt saves the flags byte and then the program counter, so the low PC byte ends on top. A return or an interrupt return reads the same bytes back in the opposite order and presents the restored PC and flags.

There are two pointer modes. In internal mode the stack lives in an 8-bit register space. Only the lower pointer byte forms the address, and it wraps modulo 256. The upper pointer byte is never read and never changed. In external mode all 16 bits address data memory and borrow across the byte boundary. The memory is outside the block and answers a read in the same cycle. The controller is a single state machine.

- `ST_IDLE` accepts a command.
- `ST_PUSH_FLG`, `ST_PUSH_PCH`, `ST_PUSH_PCL` and `ST_PUSH_BYTE` are write cycles.
- `ST_POP_PCL`, `ST_POP_PCH`, `ST_POP_FLG` and `ST_POP_BYTE` are read cycles.

Its transitions are:

- IDLE→PUSH_FLG on interrupt entry.
- IDLE→PUSH_PCH on a call.
- IDLE→POP_PCL on a return or an interrupt return.
- IDLE→PUSH_BYTE on a byte push.
- IDLE→POP_BYTE on a byte pop.
- PUSH_FLG→PUSH_PCH→PUSH_PCL→IDLE.
- POP_PCL→POP_PCH.
- POP_PCH→POP_FLG when the frame is an interrupt frame, otherwise POP_PCH→IDLE.
- POP_FLG→IDLE.
- PUSH_BYTE→IDLE and POP_BYTE→IDLE.

Top module: `stkptr_engine`

## Requirements
- R1: A byte push, one cycle after the command is accepted, first lowers the pointer by one. It writes `push_data` at the lowered pointer, with `mem_we` high for exactly that one cycle.
- R2: A byte pop reads the byte at the current pointer with `mem_re` high for one cycle. It places that byte on `pop_data` and then raises the pointer by one.
- R3: A call writes the high PC byte and then the low PC byte in two consecutive cycles. The pointer ends two lower, addressing the low byte.
- R4: A return reads the low PC byte and then the high PC byte. It updates `pc_out` and leaves the pointer two higher.
- R5: An interrupt writes flags, then the high PC byte, then the low PC byte in three consecutive cycles. The pointer ends three lower.
- R6: An interrupt return reads the low PC byte, the high PC byte and then flags. It updates `pc_out` and `flags_out` and leaves the pointer three higher.
- R7: In internal mode (`mode_ext`=0), `mem_addr[15:8]` is zero. The upper pointer byte stays unchanged. The lower byte wraps modulo 256 (00h→FFh on a push, FFh→00h on a pop).
- R8: In external mode (`mode_ext`=1), `mem_addr` is the full 16-bit pointer, and decrements borrow from the upper byte (A000h→9FFFh).
- R9: `busy` is high from the cycle after acceptance through the last byte cycle of the frame. Strobes seen while `busy` is high are ignored, and so are strobes in the cycle where it falls.
- R10: When several strobes are high together, only one is taken. The order is interrupt, then call, then interrupt return, then return, then byte push, then byte pop.
- R11: After reset the pointer equals `SP_RESET` (default A000h). `busy`, `mem_we` and `mem_re` are low, and `pc_out`, `flags_out` and `pop_data` are zero.
- R12: The mode is sampled when a command is accepted and holds for the whole frame, whatever `mode_ext` does meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ext | input | 1 | 1: 16-bit external pointer, 0: 8-bit internal pointer |
| cmd_push | input | 1 | Push one byte |
| cmd_pop | input | 1 | Pop one byte |
| cmd_call | input | 1 | Save the PC for a subroutine call |
| cmd_ret | input | 1 | Restore the PC on return |
| cmd_int | input | 1 | Save flags and PC for interrupt entry |
| cmd_iret | input | 1 | Restore PC and flags on interrupt return |
| push_data | input | 8 | Byte for a single push |
| pc_in | input | 16 | Program counter to save |
| flags_in | input | 8 | Flags byte to save |
| rd_data | input | 8 | Memory read data for `mem_addr`, same cycle |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| pop_data | output | 8 | Last byte from a single pop |
| pc_out | output | 16 | Restored program counter |
| flags_out | output | 8 | Restored flags |
| sp_out | output | 16 | Current stack pointer |
| busy | output | 1 | Frame in progress, commands ignored |

## Verification
The assertions assume three things about the inputs:

- `rd_data` reflects `mem_addr` within the same cycle.
- Strobes are plain levels sampled only in the accept state.
- The bench's memory never returns undefined bytes.

The stimulus meets these conditions in a specific way. The bench models a memory that returns zero for unwritten cells. It refreshes `rd_data` right after every edge from the address the design presents. It drives strobes only on falling edges. Overlapping strobes, strobes held during a frame, and a mode flip in the middle of a frame are all applied on purpose. Their effect on the pointer and the outputs is checked against the model.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FLG,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_BYTE,
        ST_POP_PCL,
        ST_POP_PCH,
        ST_POP_FLG,
        ST_POP_BYTE
    } stk_state_e;
endpackage

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
    parameter int BYTE_W = 8,
    parameter logic [2*BYTE_W-1:0] SP_RESET = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_mode,
    input  logic                step_dn,
    input  logic                step_up,
    output logic [2*BYTE_W-1:0] sp,
    output logic [2*BYTE_W-1:0] push_addr,
    output logic [2*BYTE_W-1:0] pop_addr
);
    localparam int PTR_W = 2 * BYTE_W;

    logic [PTR_W-1:0] sp_dn, sp_up;
    logic [BYTE_W-1:0] lo_dn, lo_up;

    always_comb begin
        lo_dn = sp[BYTE_W-1:0] - 1'b1;
        lo_up = sp[BYTE_W-1:0] + 1'b1;
        if (ext_mode) begin
            sp_dn = sp - 1'b1;
            sp_up = sp + 1'b1;
            push_addr = sp_dn;
            pop_addr  = sp;
        end else begin
            sp_dn = {sp[PTR_W-1:BYTE_W], lo_dn};
            sp_up = {sp[PTR_W-1:BYTE_W], lo_up};
            push_addr = {{BYTE_W{1'b0}}, lo_dn};
            pop_addr  = {{BYTE_W{1'b0}}, sp[BYTE_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       sp <= SP_RESET;
        else if (step_dn) sp <= sp_dn;
        else if (step_up) sp <= sp_up;
    end

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_dn && step_up)); // R1
    AST_INT_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && (step_dn || step_up)) |=> $stable(sp[PTR_W-1:BYTE_W])); // R7
endmodule

// File: rtl/stk_frame_fsm.sv
module stk_frame_fsm
    import stk_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_in,
    input  logic                cmd_push,
    input  logic                cmd_pop,
    input  logic                cmd_call,
    input  logic                cmd_ret,
    input  logic                cmd_int,
    input  logic                cmd_iret,
    input  logic [BYTE_W-1:0]   push_data,
    input  logic [2*BYTE_W-1:0] pc_in,
    input  logic [BYTE_W-1:0]   flags_in,
    input  logic [BYTE_W-1:0]   rd_data,
    input  logic [2*BYTE_W-1:0] push_addr,
    input  logic [2*BYTE_W-1:0] pop_addr,
    output logic                ext_mode,
    output logic                step_dn,
    output logic                step_up,
    output logic [2*BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    output logic                busy,
    output logic [2*BYTE_W-1:0] pc_out,
    output logic [BYTE_W-1:0]   flags_out,
    output logic [BYTE_W-1:0]   pop_data
);
    localparam int PTR_W = 2 * BYTE_W;

    stk_state_e state, nxt;
    logic [PTR_W-1:0]  pc_q;
    logic [BYTE_W-1:0] flg_q, byte_q;
    logic              irq_frame_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_int)                  nxt = ST_PUSH_FLG;
                else if (cmd_call)            nxt = ST_PUSH_PCH;
                else if (cmd_iret || cmd_ret) nxt = ST_POP_PCL;
                else if (cmd_push)            nxt = ST_PUSH_BYTE;
                else if (cmd_pop)             nxt = ST_POP_BYTE;
            end
            ST_PUSH_FLG:  nxt = ST_PUSH_PCH;
            ST_PUSH_PCH:  nxt = ST_PUSH_PCL;
            ST_PUSH_PCL:  nxt = ST_IDLE;
            ST_PUSH_BYTE: nxt = ST_IDLE;
            ST_POP_PCL:   nxt = ST_POP_PCH;
            ST_POP_PCH:   nxt = irq_frame_q ? ST_POP_FLG : ST_IDLE;
            ST_POP_FLG:   nxt = ST_IDLE;
            ST_POP_BYTE:  nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        step_dn   = 1'b0;
        step_up   = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        busy      = (state != ST_IDLE);
        unique case (state)
            ST_PUSH_FLG, ST_PUSH_PCH, ST_PUSH_PCL, ST_PUSH_BYTE: begin
                step_dn  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = push_addr;
            end
            ST_POP_PCL, ST_POP_PCH, ST_POP_FLG, ST_POP_BYTE: begin
                step_up  = 1'b1;
                mem_re   = 1'b1;
                mem_addr = pop_addr;
            end
            default: ;
        endcase
        unique case (state)
            ST_PUSH_FLG:  mem_wdata = flg_q;
            ST_PUSH_PCH:  mem_wdata = pc_q[PTR_W-1:BYTE_W];
            ST_PUSH_PCL:  mem_wdata = pc_q[BYTE_W-1:0];
            ST_PUSH_BYTE: mem_wdata = byte_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q        <= '0;
            flg_q       <= '0;
            byte_q      <= '0;
            irq_frame_q <= 1'b0;
            ext_mode    <= 1'b0;
            pc_out      <= '0;
            flags_out   <= '0;
            pop_data    <= '0;
        end else begin
            if (state == ST_IDLE && nxt != ST_IDLE) begin
                pc_q        <= pc_in;
                flg_q       <= flags_in;
                byte_q      <= push_data;
                ext_mode    <= mode_in;
                irq_frame_q <= !cmd_int && !cmd_call && cmd_iret;
            end
            if (state == ST_POP_PCL)  pc_out[BYTE_W-1:0]     <= rd_data;
            if (state == ST_POP_PCH)  pc_out[PTR_W-1:BYTE_W] <= rd_data;
            if (state == ST_POP_FLG)  flags_out              <= rd_data;
            if (state == ST_POP_BYTE) pop_data               <= rd_data;
        end
    end

    AST_FLG_THEN_PCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_FLG) |=> (state == ST_PUSH_PCH)); // R5
    AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy); // R9
    AST_RET_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POP_PCH && !irq_frame_q) |=> !busy); // R4
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ext_mode)); // R12
endmodule

// File: rtl/stkptr_engine.sv
module stkptr_engine #(
    parameter int          BYTE_W   = 8,
    parameter logic [15:0] SP_RESET = 16'hA000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_ext,
    input  logic                cmd_push,
    input  logic                cmd_pop,
    input  logic                cmd_call,
    input  logic                cmd_ret,
    input  logic                cmd_int,
    input  logic                cmd_iret,
    input  logic [BYTE_W-1:0]   push_data,
    input  logic [2*BYTE_W-1:0] pc_in,
    input  logic [BYTE_W-1:0]   flags_in,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [2*BYTE_W-1:0] mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    output logic                mem_we,
    output logic                mem_re,
    output logic [BYTE_W-1:0]   pop_data,
    output logic [2*BYTE_W-1:0] pc_out,
    output logic [BYTE_W-1:0]   flags_out,
    output logic [2*BYTE_W-1:0] sp_out,
    output logic                busy
);
    localparam int PTR_W = 2 * BYTE_W;

    logic             ext_mode, step_dn, step_up;
    logic [PTR_W-1:0] push_addr, pop_addr;

    stk_ptr_unit #(.BYTE_W(BYTE_W), .SP_RESET(PTR_W'(SP_RESET))) u_ptr (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode),
        .step_dn(step_dn), .step_up(step_up), .sp(sp_out),
        .push_addr(push_addr), .pop_addr(pop_addr)
    );

    stk_frame_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_ext),
        .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call),
        .cmd_ret(cmd_ret), .cmd_int(cmd_int), .cmd_iret(cmd_iret),
        .push_data(push_data), .pc_in(pc_in), .flags_in(flags_in),
        .rd_data(rd_data), .push_addr(push_addr), .pop_addr(pop_addr),
        .ext_mode(ext_mode), .step_dn(step_dn), .step_up(step_up),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_re(mem_re), .busy(busy), .pc_out(pc_out),
        .flags_out(flags_out), .pop_data(pop_data)
    );

    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out[BYTE_W-1:0] == $past(mem_addr[BYTE_W-1:0]))); // R1
    AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (sp_out[BYTE_W-1:0] == BYTE_W'($past(mem_addr[BYTE_W-1:0]) + 1'b1))); // R2
    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R9
    AST_INT_ADDR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && !ext_mode) |-> (mem_addr[PTR_W-1:BYTE_W] == '0)); // R7
endmodule

// File: tb/stkptr_engine_test.sv
module stkptr_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ext = 1'b1;
    logic cmd_push = 0, cmd_pop = 0, cmd_call = 0, cmd_ret = 0, cmd_int = 0, cmd_iret = 0;
    logic [7:0]  push_data = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  flags_in = 8'h00;
    logic [7:0]  rd_data = 8'h00;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata, pop_data, flags_out;
    logic        mem_we, mem_re, busy;

    always #2 clk = ~clk;

    stkptr_engine uut (
        .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext),
        .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call),
        .cmd_ret(cmd_ret), .cmd_int(cmd_int), .cmd_iret(cmd_iret),
        .push_data(push_data), .pc_in(pc_in), .flags_in(flags_in),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .pop_data(pop_data),
        .pc_out(pc_out), .flags_out(flags_out), .sp_out(sp_out), .busy(busy)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R11";

    // reference model: queue of pending byte operations
    // op[8]=0: write op[7:0]; op[8]=1: read into target op[1:0] (0 byte,1 pcl,2 pch,3 flags)
    int          q[$];
    logic [15:0] m_sp = 16'hA000;
    logic        m_ext = 1'b0;
    logic [15:0] m_pc = 16'h0;
    logic [7:0]  m_flg = 8'h0, m_pop = 8'h0;
    logic [7:0]  mem [logic [15:0]];

    function automatic logic [15:0] place(input logic [15:0] s);
        return m_ext ? s : {8'h00, s[7:0]};
    endfunction
    function automatic logic [15:0] lowered(input logic [15:0] s);
        return m_ext ? s - 16'd1 : {s[15:8], s[7:0] - 8'd1};
    endfunction
    function automatic logic [15:0] raised(input logic [15:0] s);
        return m_ext ? s + 16'd1 : {s[15:8], s[7:0] + 8'd1};
    endfunction
    function automatic logic [7:0] peek(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        int op;
        logic [7:0] v;
        if (!rst_n) begin
            q.delete();
            m_sp = 16'hA000; m_pc = 0; m_flg = 0; m_pop = 0; m_ext = 0;
        end else if (q.size() != 0) begin
            op = q.pop_front();
            if (op[8] == 1'b0) begin
                m_sp = lowered(m_sp);
                mem[place(m_sp)] = op[7:0];
            end else begin
                v = peek(place(m_sp));
                case (op[1:0])
                    2'd0: m_pop = v;
                    2'd1: m_pc[7:0] = v;
                    2'd2: m_pc[15:8] = v;
                    default: m_flg = v;
                endcase
                m_sp = raised(m_sp);
            end
        end else begin
            m_ext = mode_ext;
            if (cmd_int) begin
                q.push_back({24'd0, flags_in}); q.push_back({24'd0, pc_in[15:8]});
                q.push_back({24'd0, pc_in[7:0]});
            end else if (cmd_call) begin
                q.push_back({24'd0, pc_in[15:8]}); q.push_back({24'd0, pc_in[7:0]});
            end else if (cmd_iret) begin
                q.push_back(257); q.push_back(258); q.push_back(259);
            end else if (cmd_ret) begin
                q.push_back(257); q.push_back(258);
            end else if (cmd_push) begin
                q.push_back({24'd0, push_data});
            end else if (cmd_pop) begin
                q.push_back(256);
            end
        end
    end

    // per-cycle comparison, away from the edge; then serve read data
    always @(posedge clk) begin
        logic e_busy, e_we, e_re;
        logic [15:0] e_addr;
        logic [7:0] e_wd;
        bit bad;
        #1;
        if (rst_n && !done) begin
            e_busy = (q.size() != 0);
            e_we = e_busy && (q[0] < 256);
            e_re = e_busy && (q[0] >= 256);
            e_addr = e_we ? place(lowered(m_sp)) : place(m_sp);
            e_wd = e_we ? q[0][7:0] : 8'h00;
            bad = (busy !== e_busy) || (mem_we !== e_we) || (mem_re !== e_re) ||
                  (sp_out !== m_sp) || (pc_out !== m_pc) || (flags_out !== m_flg) ||
                  (pop_data !== m_pop) || ((e_we || e_re) && mem_addr !== e_addr) ||
                  (e_we && mem_wdata !== e_wd);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s t=%0t act busy=%b we=%b re=%b addr=%h wd=%h sp=%h pc=%h fl=%h pop=%h exp busy=%b we=%b re=%b addr=%h wd=%h sp=%h pc=%h fl=%h pop=%h",
                    cur_req, $time, busy, mem_we, mem_re, mem_addr, mem_wdata, sp_out, pc_out, flags_out, pop_data,
                    e_busy, e_we, e_re, e_addr, e_wd, m_sp, m_pc, m_flg, m_pop);
            end
        end
        rd_data = peek(mem_addr);
    end

    task automatic fire(input logic [5:0] m);
        @(negedge clk);
        {cmd_iret, cmd_int, cmd_ret, cmd_call, cmd_pop, cmd_push} = m;
        @(negedge clk);
        {cmd_iret, cmd_int, cmd_ret, cmd_call, cmd_pop, cmd_push} = 6'b0;
        repeat (4) @(negedge clk);
    endtask

    localparam logic [5:0] C_PUSH = 6'b000001, C_POP = 6'b000010, C_CALL = 6'b000100,
                           C_RET = 6'b001000, C_INT = 6'b010000, C_IRET = 6'b100000;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R11 reset state
        if (sp_out !== 16'hA000 || busy !== 1'b0 || mem_we !== 1'b0 || mem_re !== 1'b0 ||
            pc_out !== 16'h0 || flags_out !== 8'h0 || pop_data !== 8'h0) begin
            errors++;
            $display("FAIL R11 act sp=%h busy=%b we=%b re=%b pc=%h fl=%h pop=%h exp sp=a000 others 0",
                     sp_out, busy, mem_we, mem_re, pc_out, flags_out, pop_data);
        end
        rst_n = 1'b1;
        mode_ext = 1'b1;
        cur_req = "R1/R8"; push_data = 8'h11; fire(C_PUSH);
        push_data = 8'h22; fire(C_PUSH);
        cur_req = "R2"; fire(C_POP); fire(C_POP);
        cur_req = "R3"; pc_in = 16'h1234; fire(C_CALL);
        cur_req = "R4"; pc_in = 16'h0000; fire(C_RET);
        cur_req = "R5"; pc_in = 16'hBEEF; flags_in = 8'h5A; fire(C_INT);
        cur_req = "R6"; fire(C_IRET);
        cur_req = "R7"; mode_ext = 1'b0; push_data = 8'h33; fire(C_PUSH);
        fire(C_POP);
        pc_in = 16'h4321; fire(C_CALL); fire(C_RET);
        flags_in = 8'hC3; pc_in = 16'h8001; fire(C_INT); fire(C_IRET);
        cur_req = "R9"; mode_ext = 1'b1; pc_in = 16'h2468;
        @(negedge clk); cmd_call = 1'b1;
        @(negedge clk); cmd_call = 1'b0; cmd_push = 1'b1; cmd_pop = 1'b1; push_data = 8'h99;
        @(negedge clk);
        @(negedge clk); cmd_push = 1'b0; cmd_pop = 1'b0;
        repeat (3) @(negedge clk);
        fire(C_RET);
        cur_req = "R10"; pc_in = 16'h1357; flags_in = 8'hA5; push_data = 8'h77;
        fire(6'b111111);
        fire(C_IRET | C_RET | C_PUSH | C_POP);
        fire(C_RET | C_PUSH | C_POP); // pops two bytes below
        push_data = 8'h44; fire(C_PUSH | C_POP);
        cur_req = "R12"; mode_ext = 1'b1; pc_in = 16'hCAFE; flags_in = 8'h0F;
        @(negedge clk); cmd_int = 1'b1;
        @(negedge clk); cmd_int = 1'b0; mode_ext = 1'b0;
        repeat (4) @(negedge clk);
        mode_ext = 1'b1; fire(C_IRET);
        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            done = 1;
            summary();
        end
    end
endmodule